// File: doc/BRIEF.md
# Two-Sided Mailbox Message Registers

This block lets two agents, side A and side B, pass 32-bit words to each other over a small set of independent message channels. Each direction has its own set of channels. When a side writes channel n, the word lands in that side's outgoing slot for channel n. The other side then sees it as a pending incoming word on channel n. Reading the word on the receiving side consumes it, and the slot becomes free again for the sender. Both sides run on one shared clock.

Each side sees a packed status field with one free-slot bit per outgoing channel and one pending-word bit per incoming channel. The ordering inside each half is reversed, so channel 0 sits at the top bit. Hardware alone updates these bits, as a side effect of data writes and reads. Each side has an enable field of the same shape, and a registered level interrupt that fires when any enabled status bit is set. A sticky per-channel overrun bit records that a sender wrote a slot before its word was consumed.

Top module: `mbox_duplex`

## Requirements
- R1: After reset, each side's status equals 8'hF0 (all outgoing slots free, no words pending), each enable field is 0, each irq is low and each overrun field is 0.
- R2: A write on one side to channel n clears that side's free bit for n one cycle later. In the same cycle, the other side's pending bit for n is set and its read data for channel n shows the written word. Channels and directions are independent.
- R3: A read strobe on the receiving side for a pending channel n clears that pending bit one cycle later and sets the sender's free bit for n. A read strobe on a channel with no pending word changes no status bit.
- R4: The status layout for NCH=4 puts the free bit of outgoing channel n at bit 7-n and the pending bit of incoming channel n at bit 3-n. The enable field uses the same positions.
- R5: The enable set and clear inputs never change any status bit. Only data writes and reads do.
- R6: The enable field updates as (en & ~clr) | set. When a bit is both set and cleared in the same cycle, set wins.
- R7: irq is high in a cycle exactly when the previous cycle had at least one status bit set whose enable bit was also set.
- R8: A write to a channel whose previous word is still pending replaces the word and leaves the pending bit set. It also sets that sender's overrun bit for the channel, at bit 3-n, and the bit stays set until reset.
- R9: A write and a read of the same channel in the same cycle keep the pending bit set, deliver the new word and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_wr_ch | input | 2 | Side A outgoing channel index |
| a_wr_data | input | 32 | Side A word to send |
| a_rd_en | input | 1 | Side A read strobe, consumes a pending word |
| a_rd_ch | input | 2 | Side A incoming channel index |
| a_rd_data | output | 32 | Side A incoming word of channel a_rd_ch |
| a_en_set | input | 8 | Side A enable bits to set |
| a_en_clr | input | 8 | Side A enable bits to clear |
| a_status | output | 8 | Side A free and pending flags |
| a_en | output | 8 | Side A enable field |
| a_ovr | output | 4 | Side A sticky overrun per outgoing channel |
| a_irq | output | 1 | Side A level interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_wr_ch | input | 2 | Side B outgoing channel index |
| b_wr_data | input | 32 | Side B word to send |
| b_rd_en | input | 1 | Side B read strobe |
| b_rd_ch | input | 2 | Side B incoming channel index |
| b_rd_data | output | 32 | Side B incoming word of channel b_rd_ch |
| b_en_set | input | 8 | Side B enable bits to set |
| b_en_clr | input | 8 | Side B enable bits to clear |
| b_status | output | 8 | Side B free and pending flags |
| b_en | output | 8 | Side B enable field |
| b_ovr | output | 4 | Side B sticky overrun per outgoing channel |
| b_irq | output | 1 | Side B level interrupt |

## Verification
The hardest case to reach from the ports is a write and a read of the same channel in the same cycle. This needs the sender and the receiver to pick the same index while a word is already pending. A second hard case is an overwrite of a pending word. Random stimulus draws channel indices from only four values and issues reads less often than writes, so overwrites and collisions occur often. Directed steps also force each case on channel 0 and channel 3, where the reversed bit order is easiest to get wrong.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Reverse the low n bits of v; bits above n are zero.
  function automatic logic [31:0] mirror_low(input logic [31:0] v, input int unsigned n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) r[n - 1 - i] = v[i];
    end
    return r;
  endfunction

  // Next value of an enable field, set has priority over clear.
  function automatic logic [31:0] en_next(input logic [31:0] cur, input logic [31:0] set,
                                          input logic [31:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          ovr
);
  logic ev_overrun;
  logic ev_drain;

  assign ev_overrun = push && valid && !pop;
  assign ev_drain   = pop && valid && !push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (push) begin
        data  <= wdata;
        valid <= 1'b1;
      end else if (pop) begin
        valid <= 1'b0;
      end
      if (ev_overrun) ovr <= 1'b1;
    end
  end

  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (valid && data == $past(wdata))); // R2
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain |=> !valid); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(valid)); // R5
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> ovr); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr); // R8
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !ovr) |=> (valid && !ovr)); // R9
endmodule

// File: rtl/mbox_side.sv
module mbox_side #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tx_valid,
  input  logic [NCH-1:0]   rx_valid,
  input  logic [2*NCH-1:0] en_set,
  input  logic [2*NCH-1:0] en_clr,
  output logic [2*NCH-1:0] status,
  output logic [2*NCH-1:0] en,
  output logic             irq
);
  import mbox_pkg::*;
  localparam int FW = 2 * NCH;

  logic [31:0]   free_m;
  logic [31:0]   pend_m;
  logic [31:0]   en_n;
  logic [FW-1:0] hits;
  logic          irq_d;

  assign free_m = mirror_low(32'(~tx_valid), NCH);
  assign pend_m = mirror_low(32'(rx_valid), NCH);
  assign status = {free_m[NCH-1:0], pend_m[NCH-1:0]};
  assign en_n   = en_next(32'(en), 32'(en_set), 32'(en_clr));
  assign hits   = status & en;
  assign irq_d  = |hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      irq <= 1'b0;
    end else begin
      en  <= en_n[FW-1:0];
      irq <= irq_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> ((en & $past(en_set)) == $past(en_set))); // R6
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_clr & ~en_set)) |=> ((en & $past(en_clr & ~en_set)) == '0)); // R6
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq); // R7
endmodule

// File: rtl/mbox_duplex.sv
module mbox_duplex #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic [CW-1:0] a_wr_ch,
  input  logic [DW-1:0] a_wr_data,
  input  logic          a_rd_en,
  input  logic [CW-1:0] a_rd_ch,
  output logic [DW-1:0] a_rd_data,
  input  logic [FW-1:0] a_en_set,
  input  logic [FW-1:0] a_en_clr,
  output logic [FW-1:0] a_status,
  output logic [FW-1:0] a_en,
  output logic [NCH-1:0] a_ovr,
  output logic          a_irq,
  input  logic          b_wr_en,
  input  logic [CW-1:0] b_wr_ch,
  input  logic [DW-1:0] b_wr_data,
  input  logic          b_rd_en,
  input  logic [CW-1:0] b_rd_ch,
  output logic [DW-1:0] b_rd_data,
  input  logic [FW-1:0] b_en_set,
  input  logic [FW-1:0] b_en_clr,
  output logic [FW-1:0] b_status,
  output logic [FW-1:0] b_en,
  output logic [NCH-1:0] b_ovr,
  output logic          b_irq
);
  import mbox_pkg::*;

  logic [NCH-1:0] push_ab, pop_ab, vld_ab, ovr_ab;
  logic [NCH-1:0] push_ba, pop_ba, vld_ba, ovr_ba;
  logic [DW-1:0]  dat_ab [NCH];
  logic [DW-1:0]  dat_ba [NCH];
  logic [31:0]    ovr_a_m, ovr_b_m;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign push_ab[n] = a_wr_en && (a_wr_ch == CW'(n));
    assign pop_ab[n]  = b_rd_en && (b_rd_ch == CW'(n));
    assign push_ba[n] = b_wr_en && (b_wr_ch == CW'(n));
    assign pop_ba[n]  = a_rd_en && (a_rd_ch == CW'(n));

    mbox_chan #(.DW(DW)) u_ab (
      .clk(clk), .rst_n(rst_n), .push(push_ab[n]), .pop(pop_ab[n]),
      .wdata(a_wr_data), .data(dat_ab[n]), .valid(vld_ab[n]), .ovr(ovr_ab[n]));
    mbox_chan #(.DW(DW)) u_ba (
      .clk(clk), .rst_n(rst_n), .push(push_ba[n]), .pop(pop_ba[n]),
      .wdata(b_wr_data), .data(dat_ba[n]), .valid(vld_ba[n]), .ovr(ovr_ba[n]));
  end

  assign b_rd_data = dat_ab[b_rd_ch];
  assign a_rd_data = dat_ba[a_rd_ch];

  assign ovr_a_m = mirror_low(32'(ovr_ab), NCH);
  assign ovr_b_m = mirror_low(32'(ovr_ba), NCH);
  assign a_ovr   = ovr_a_m[NCH-1:0];
  assign b_ovr   = ovr_b_m[NCH-1:0];

  mbox_side #(.NCH(NCH)) u_side_a (
    .clk(clk), .rst_n(rst_n), .tx_valid(vld_ab), .rx_valid(vld_ba),
    .en_set(a_en_set), .en_clr(a_en_clr), .status(a_status), .en(a_en), .irq(a_irq));
  mbox_side #(.NCH(NCH)) u_side_b (
    .clk(clk), .rst_n(rst_n), .tx_valid(vld_ba), .rx_valid(vld_ab),
    .en_set(b_en_set), .en_clr(b_en_clr), .status(b_status), .en(b_en), .irq(b_irq));

  AST_VIEWS_AGREE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    a_status[FW-1:NCH] == ~b_status[NCH-1:0]); // R3
  AST_VIEWS_AGREE_BA: assert property (@(posedge clk) disable iff (!rst_n)
    b_status[FW-1:NCH] == ~a_status[NCH-1:0]); // R3
  AST_ENABLES_NO_FLAG_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_wr_en && !a_rd_en && !b_wr_en && !b_rd_en) |=> $stable(a_status)); // R5
endmodule

// File: tb/sim_mbox_duplex.sv
module sim_mbox_duplex;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [1:0] a_wr_ch = 0, a_rd_ch = 0, b_wr_ch = 0, b_rd_ch = 0;
  logic [31:0] a_wr_data = 0, b_wr_data = 0;
  logic [7:0] a_en_set = 0, a_en_clr = 0, b_en_set = 0, b_en_clr = 0;
  logic [31:0] a_rd_data, b_rd_data;
  logic [7:0] a_status, b_status, a_en, b_en;
  logic [3:0] a_ovr, b_ovr;
  logic a_irq, b_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model, indexed by channel number
  logic [3:0]  m_vab, m_vba, m_oa, m_ob;
  logic [31:0] m_dab [4];
  logic [31:0] m_dba [4];
  logic [7:0]  m_ena, m_enb;
  logic        m_irqa, m_irqb;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_duplex u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_ch(a_wr_ch), .a_wr_data(a_wr_data),
    .a_rd_en(a_rd_en), .a_rd_ch(a_rd_ch), .a_rd_data(a_rd_data),
    .a_en_set(a_en_set), .a_en_clr(a_en_clr), .a_status(a_status), .a_en(a_en),
    .a_ovr(a_ovr), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_wr_ch(b_wr_ch), .b_wr_data(b_wr_data),
    .b_rd_en(b_rd_en), .b_rd_ch(b_rd_ch), .b_rd_data(b_rd_data),
    .b_en_set(b_en_set), .b_en_clr(b_en_clr), .b_status(b_status), .b_en(b_en),
    .b_ovr(b_ovr), .b_irq(b_irq));

  // channel n -> bit 3-n
  function automatic logic [3:0] flip4(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  function automatic logic [7:0] stat_of(input logic [3:0] out_v, input logic [3:0] in_v);
    return {flip4(~out_v), flip4(in_v)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R4 a_status", 32'(a_status), 32'(stat_of(m_vab, m_vba)));
    chk("R2 R3 R4 b_status", 32'(b_status), 32'(stat_of(m_vba, m_vab)));
    chk("R2 a_rd_data", a_rd_data, m_dba[a_rd_ch]);
    chk("R2 b_rd_data", b_rd_data, m_dab[b_rd_ch]);
    chk("R6 a_en", 32'(a_en), 32'(m_ena));
    chk("R6 b_en", 32'(b_en), 32'(m_enb));
    chk("R8 a_ovr", 32'(a_ovr), 32'(flip4(m_oa)));
    chk("R8 b_ovr", 32'(b_ovr), 32'(flip4(m_ob)));
    chk("R7 a_irq", 32'(a_irq), 32'(m_irqa));
    chk("R7 b_irq", 32'(b_irq), 32'(m_irqb));
  endtask

  // advance the model by one clock with the inputs now driven
  task automatic model_step();
    logic [7:0] sa, sb;
    sa = stat_of(m_vab, m_vba);
    sb = stat_of(m_vba, m_vab);
    m_irqa = |(sa & m_ena);
    m_irqb = |(sb & m_enb);
    m_ena = (m_ena & ~a_en_clr) | a_en_set;
    m_enb = (m_enb & ~b_en_clr) | b_en_set;
    for (int n = 0; n < 4; n++) begin
      logic pu, po;
      pu = a_wr_en && a_wr_ch == 2'(n);
      po = b_rd_en && b_rd_ch == 2'(n);
      if (pu) begin
        if (m_vab[n] && !po) m_oa[n] = 1'b1;
        m_vab[n] = 1'b1;
        m_dab[n] = a_wr_data;
      end else if (po) m_vab[n] = 1'b0;
      pu = b_wr_en && b_wr_ch == 2'(n);
      po = a_rd_en && a_rd_ch == 2'(n);
      if (pu) begin
        if (m_vba[n] && !po) m_ob[n] = 1'b1;
        m_vba[n] = 1'b1;
        m_dba[n] = b_wr_data;
      end else if (po) m_vba[n] = 1'b0;
    end
  endtask

  task automatic idle();
    a_wr_en = 0; a_rd_en = 0; b_wr_en = 0; b_rd_en = 0;
    a_en_set = 0; a_en_clr = 0; b_en_set = 0; b_en_clr = 0;
  endtask

  // inputs are already driven (after a negedge); clock once and check
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_vab = 0; m_vba = 0; m_oa = 0; m_ob = 0; m_ena = 0; m_enb = 0;
    m_irqa = 0; m_irqb = 0;
    for (int n = 0; n < 4; n++) begin m_dab[n] = 0; m_dba[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a_status", 32'(a_status), 32'h0000_00F0);
    chk("R1 b_status", 32'(b_status), 32'h0000_00F0);
    chk("R1 a_en", 32'(a_en), 0);
    chk("R1 a_irq", 32'(a_irq), 0);
    chk("R1 b_ovr", 32'(b_ovr), 0);

    // R4: A writes channel 0 -> A status bit 7 clears, B status bit 3 sets
    a_wr_en = 1; a_wr_ch = 0; a_wr_data = 32'hCAFE_0000; b_rd_ch = 0;
    tick();
    chk("R4 a_status ch0", 32'(a_status), 32'h0000_0070);
    chk("R4 b_status ch0", 32'(b_status), 32'h0000_00F8);
    // R5: clear all enables does not touch flags
    a_en_clr = 8'hFF; b_en_clr = 8'hFF;
    tick();
    // R7: enable B pending ch0 (bit 3); irq one cycle after enable is seen
    b_en_set = 8'h08;
    tick();
    chk("R7 b_irq not yet", 32'(b_irq), 0);
    tick();
    chk("R7 b_irq raised", 32'(b_irq), 1);
    // R8: overwrite pending word on channel 0
    a_wr_en = 1; a_wr_ch = 0; a_wr_data = 32'h1111_2222;
    tick();
    chk("R8 overwrite data", b_rd_data, 32'h1111_2222);
    chk("R8 a_ovr bit3", 32'(a_ovr), 32'h8);
    // R9: collide write+read on channel 3 from B to A
    b_wr_en = 1; b_wr_ch = 3; b_wr_data = 32'hAAAA_0003;
    tick();
    a_rd_ch = 3; a_rd_en = 1; b_wr_en = 1; b_wr_ch = 3; b_wr_data = 32'hBBBB_0003;
    tick();
    chk("R9 collide no ovr", 32'(b_ovr), 0);
    chk("R9 collide pending bit0", 32'(a_status[0]), 1);
    // R3: consume, then read of empty channel does nothing
    a_rd_en = 1; a_rd_ch = 3;
    tick();
    chk("R3 drained", 32'(a_status[0]), 0);
    a_rd_en = 1; a_rd_ch = 2; b_rd_en = 1; b_rd_ch = 1;
    tick();
    // R6: set and clear same bit, set wins
    a_en_set = 8'h81; a_en_clr = 8'hFF;
    tick();
    chk("R6 set wins", 32'(a_en), 32'h81);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      a_wr_en = ($urandom % 3) == 0; a_wr_ch = 2'($urandom); a_wr_data = $urandom;
      b_wr_en = ($urandom % 3) == 0; b_wr_ch = 2'($urandom); b_wr_data = $urandom;
      a_rd_en = ($urandom % 4) == 0; a_rd_ch = 2'($urandom);
      b_rd_en = ($urandom % 4) == 0; b_rd_ch = 2'($urandom);
      if (($urandom % 8) == 0) begin a_en_set = 8'($urandom); a_en_clr = 8'($urandom); end
      if (($urandom % 8) == 0) begin b_en_set = 8'($urandom); b_en_clr = 8'($urandom); end
      tick();
    end
    finish_run();
  end
endmodule